// File: doc/BRIEF.md
# Asynchronous Static RAM Controller with Byte Lanes

This block connects a clocked host to an external asynchronous static RAM of 65,536 words of 16 bits. The host places a request (address, write data, a write flag and a per-byte lane mask) while `ready` is high. The controller then sequences the memory's active-low chip select, write strobe, read strobe and per-lane selects, and it controls a split data bus (`mem_dq_o`, `mem_dq_oe`, `mem_dq_i`) that board logic or a pad ring turns into a tri-state bus. Read data returns on `rsp_rdata` with a one-cycle `rsp_valid` pulse.

A programmable down-counter stretches the read access window and the write-strobe low time to `RD_CYCLES` and `WR_CYCLES` clock cycles, so one design covers every speed grade. Chip select is held inactive whenever no transfer runs, so the memory stays in standby. The data drivers are on only while the memory's outputs are shut off. Every write ends with a gap cycle that keeps the drivers off before any later read may open the memory outputs.

The sequencer has seven states. ST_IDLE (ready, standby) goes to ST_WR_SETUP on an accepted write and to ST_RD_ACCESS on an accepted read. ST_RD_ACCESS (select and read strobe low) goes to ST_RD_DONE when the counter expires and latches the data. ST_RD_DONE (standby, valid pulse) returns to ST_IDLE. ST_WR_SETUP (select low, data driven) goes to ST_WR_PULSE. ST_WR_PULSE (write strobe low) goes to ST_WR_HOLD when the counter expires. ST_WR_HOLD (strobe raised, data still driven) goes to ST_WR_GAP. ST_WR_GAP (standby, drivers off) returns to ST_IDLE.

Top module: `sram_async_ctrl`

## Requirements
- R1: During and after reset, `ready`=1, `rsp_valid`=0, `mem_dq_oe`=0, and `mem_ce_n`, `mem_we_n`, `mem_oe_n` and both bits of `mem_bsel_n` are 1.
- R2: `mem_ce_n` is 1 in every cycle where `ready` is 1, and neither strobe is low while `mem_ce_n` is 1.
- R3: A read holds `mem_ce_n`=0, `mem_oe_n`=0 and `mem_we_n`=1 for exactly `RD_CYCLES` cycles. In the cycle where `mem_oe_n` returns to 1, `rsp_valid` is 1 and `rsp_rdata` holds the word sampled at the end of the access.
- R4: A write drives the data for one setup cycle, holds `mem_we_n`=0 for exactly `WR_CYCLES` cycles, and then keeps `mem_ce_n`=0 and the data driven and unchanged in the cycle where `mem_we_n` rises.
- R5: `req_be[0]` selects data bits 7:0 through `mem_bsel_n[0]` (active low), and `req_be[1]` selects bits 15:8 through `mem_bsel_n[1]`, for both reads and writes. A write with one lane selected leaves the other byte of the word unchanged.
- R6: Read lanes that are not selected return 0 in `rsp_rdata`. A write with `req_be`=2'b00 changes no byte of memory.
- R7: `mem_dq_oe` is 1 only while `mem_oe_n` is 1, and `mem_oe_n` is 0 only while `mem_we_n` is 1.
- R8: In the cycle before any cycle where `mem_oe_n` goes low, `mem_dq_oe` is 0. After each write there is at least one cycle with `mem_ce_n`=1 and `mem_dq_oe`=0.
- R9: A request is taken only on a clock edge where `ready` is 1. `ready` is 0 from the cycle after acceptance until the transfer ends, and a request raised while `ready` is 0 has no effect.
- R10: `rsp_valid` is never high for two cycles in a row, and it appears exactly once per read and never for a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req | input | 1 | Host request, taken when `ready` is 1 |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Word address |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Lane mask, bit 0 = bits 7:0, bit 1 = bits 15:8 |
| ready | output | 1 | Controller idle and able to take a request |
| rsp_valid | output | 1 | One-cycle read data valid pulse |
| rsp_rdata | output | 16 | Read data, unselected lanes zero |
| mem_addr | output | 16 | Memory address |
| mem_ce_n | output | 1 | Chip select, active low |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_oe_n | output | 1 | Read strobe (output enable), active low |
| mem_bsel_n | output | 2 | Lane selects, active low, bit 0 lower byte |
| mem_dq_o | output | 16 | Data toward the memory |
| mem_dq_oe | output | 1 | Drive enable for `mem_dq_o` |
| mem_dq_i | input | 16 | Data from the memory |

## Verification
Full-word writes and reads at the lowest, highest and walking-bit addresses show that the address and data paths have no stuck or swapped bits. Single-lane writes followed by full and single-lane reads, with a memory model that returns junk on unselected lanes, separate correct lane steering from masking or lane-swap faults. Back-to-back write-then-read pairs expose a missing turnaround gap. A request raised while the controller is busy, followed by a read of its target, shows whether busy requests leak through.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_ACCESS,
        ST_RD_DONE,
        ST_WR_SETUP,
        ST_WR_PULSE,
        ST_WR_HOLD,
        ST_WR_GAP
    } seq_state_t;

    typedef struct packed {
        logic ce_n;
        logic we_n;
        logic oe_n;
        logic lanes_on;
        logic drive;
    } strobe_t;

    localparam strobe_t STROBE_IDLE = '{ce_n: 1'b1, we_n: 1'b1, oe_n: 1'b1,
                                         lanes_on: 1'b0, drive: 1'b0};

endpackage

// File: rtl/sram_wait_timer.sv
module sram_wait_timer #(
    parameter int CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             done
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign done = (cnt_q == '0);

endmodule

// File: rtl/sram_lane_io.sv
module sram_lane_io #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16,
    parameter int LANES  = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic [DATA_W-1:0] in_wdata,
    input  logic [LANES-1:0]  in_be,
    input  logic              capture,
    input  logic              drive,
    input  logic              lanes_on,
    input  logic [DATA_W-1:0] dq_i,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [LANES-1:0]  bsel_n,
    output logic [DATA_W-1:0] dq_o,
    output logic              dq_oe,
    output logic [DATA_W-1:0] rdata
);

    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic [LANES-1:0]  be_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
            be_q    <= '0;
        end else if (accept) begin
            addr_q  <= in_addr;
            wdata_q <= in_wdata;
            be_q    <= in_be;
        end
    end

    genvar gl;
    generate
        for (gl = 0; gl < LANES; gl++) begin : g_lane
            assign bsel_n[gl] = ~(lanes_on & be_q[gl]);

            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    rdata[gl*8 +: 8] <= '0;
                end else if (capture) begin
                    rdata[gl*8 +: 8] <= be_q[gl] ? dq_i[gl*8 +: 8] : 8'h00;
                end
            end
        end
    endgenerate

    assign mem_addr = addr_q;
    assign dq_o     = wdata_q;
    assign dq_oe    = drive;

    AST_WDATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (dq_oe && $past(dq_oe)) |-> $stable(dq_o));  // R4

    AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!(&bsel_n) && $past(!(&bsel_n))) |-> $stable(mem_addr));  // R3

endmodule

// File: rtl/sram_seq_fsm.sv
module sram_seq_fsm
    import sram_ctrl_pkg::*;
#(
    parameter int RD_CYCLES = 2,
    parameter int WR_CYCLES = 2,
    parameter int CNT_W     = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req,
    input  logic             req_we,
    input  logic             timer_done,
    output logic             ready,
    output logic             accept,
    output logic             timer_load,
    output logic [CNT_W-1:0] timer_val,
    output logic             capture,
    output logic             rvalid,
    output logic             ce_n,
    output logic             we_n,
    output logic             oe_n,
    output logic             lanes_on,
    output logic             drive
);

    localparam logic [CNT_W-1:0] RD_LOAD = CNT_W'(RD_CYCLES - 1);
    localparam logic [CNT_W-1:0] WR_LOAD = CNT_W'(WR_CYCLES - 1);

    seq_state_t state_q, state_d;
    strobe_t    strb;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d    = state_q;
        accept     = 1'b0;
        timer_load = 1'b0;
        timer_val  = RD_LOAD;
        capture    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (req) begin
                    accept = 1'b1;
                    if (req_we) begin
                        state_d = ST_WR_SETUP;
                    end else begin
                        timer_load = 1'b1;
                        state_d    = ST_RD_ACCESS;
                    end
                end
            end
            ST_RD_ACCESS: begin
                if (timer_done) begin
                    capture = 1'b1;
                    state_d = ST_RD_DONE;
                end
            end
            ST_RD_DONE:  state_d = ST_IDLE;
            ST_WR_SETUP: begin
                timer_load = 1'b1;
                timer_val  = WR_LOAD;
                state_d    = ST_WR_PULSE;
            end
            ST_WR_PULSE: begin
                if (timer_done) begin
                    state_d = ST_WR_HOLD;
                end
            end
            ST_WR_HOLD:  state_d = ST_WR_GAP;
            ST_WR_GAP:   state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        strb   = STROBE_IDLE;
        ready  = 1'b0;
        rvalid = 1'b0;
        unique case (state_q)
            ST_IDLE:      ready = 1'b1;
            ST_RD_ACCESS: begin
                strb.ce_n     = 1'b0;
                strb.oe_n     = 1'b0;
                strb.lanes_on = 1'b1;
            end
            ST_RD_DONE:   rvalid = 1'b1;
            ST_WR_SETUP, ST_WR_HOLD: begin
                strb.ce_n     = 1'b0;
                strb.lanes_on = 1'b1;
                strb.drive    = 1'b1;
            end
            ST_WR_PULSE: begin
                strb.ce_n     = 1'b0;
                strb.we_n     = 1'b0;
                strb.lanes_on = 1'b1;
                strb.drive    = 1'b1;
            end
            ST_WR_GAP:    ;
            default:      ;
        endcase
    end

    assign ce_n     = strb.ce_n;
    assign we_n     = strb.we_n;
    assign oe_n     = strb.oe_n;
    assign lanes_on = strb.lanes_on;
    assign drive    = strb.drive;

    AST_STANDBY_WHEN_READY: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> ce_n);  // R2

    AST_STROBE_NEEDS_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
        (!oe_n || !we_n) |-> !ce_n);  // R2

    AST_NO_BUS_FIGHT: assert property (@(posedge clk) disable iff (!rst_n)
        drive |-> (oe_n && we_n == we_n));  // R7

    AST_READ_WE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        !oe_n |-> we_n);  // R7

    AST_TURNAROUND_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        $past(drive) |-> oe_n);  // R8

    AST_WE_RISE_DATA_ON: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(we_n) |-> (drive && !ce_n));  // R4

    AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (req && ready) |=> !ready);  // R9

    AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rvalid |=> !rvalid);  // R10

    AST_VALID_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
        rvalid |-> $past(!oe_n));  // R3

endmodule

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl #(
    parameter int ADDR_W    = 16,
    parameter int DATA_W    = 16,
    parameter int RD_CYCLES = 2,
    parameter int WR_CYCLES = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req,
    input  logic                  req_we,
    input  logic [ADDR_W-1:0]     req_addr,
    input  logic [DATA_W-1:0]     req_wdata,
    input  logic [DATA_W/8-1:0]   req_be,
    output logic                  ready,
    output logic                  rsp_valid,
    output logic [DATA_W-1:0]     rsp_rdata,
    output logic [ADDR_W-1:0]     mem_addr,
    output logic                  mem_ce_n,
    output logic                  mem_we_n,
    output logic                  mem_oe_n,
    output logic [DATA_W/8-1:0]   mem_bsel_n,
    output logic [DATA_W-1:0]     mem_dq_o,
    output logic                  mem_dq_oe,
    input  logic [DATA_W-1:0]     mem_dq_i
);

    localparam int LANES    = DATA_W / 8;
    localparam int MAX_WAIT = (RD_CYCLES > WR_CYCLES) ? RD_CYCLES : WR_CYCLES;
    localparam int CNT_W    = (MAX_WAIT > 1) ? $clog2(MAX_WAIT) : 1;

    logic             accept;
    logic             timer_load;
    logic [CNT_W-1:0] timer_val;
    logic             timer_done;
    logic             capture;
    logic             lanes_on;
    logic             drive;

    sram_seq_fsm #(
        .RD_CYCLES (RD_CYCLES),
        .WR_CYCLES (WR_CYCLES),
        .CNT_W     (CNT_W)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .req        (req),
        .req_we     (req_we),
        .timer_done (timer_done),
        .ready      (ready),
        .accept     (accept),
        .timer_load (timer_load),
        .timer_val  (timer_val),
        .capture    (capture),
        .rvalid     (rsp_valid),
        .ce_n       (mem_ce_n),
        .we_n       (mem_we_n),
        .oe_n       (mem_oe_n),
        .lanes_on   (lanes_on),
        .drive      (drive)
    );

    sram_wait_timer #(
        .CNT_W (CNT_W)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (timer_load),
        .load_val (timer_val),
        .done     (timer_done)
    );

    sram_lane_io #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .LANES  (LANES)
    ) u_lane_io (
        .clk      (clk),
        .rst_n    (rst_n),
        .accept   (accept),
        .in_addr  (req_addr),
        .in_wdata (req_wdata),
        .in_be    (req_be),
        .capture  (capture),
        .drive    (drive),
        .lanes_on (lanes_on),
        .dq_i     (mem_dq_i),
        .mem_addr (mem_addr),
        .bsel_n   (mem_bsel_n),
        .dq_o     (mem_dq_o),
        .dq_oe    (mem_dq_oe),
        .rdata    (rsp_rdata)
    );

    AST_DRIVE_ONLY_OE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> mem_oe_n);  // R7

    AST_LANES_NEED_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
        mem_ce_n |-> (&mem_bsel_n));  // R5

endmodule

// File: tb/sram_async_ctrl_bench.sv
module sram_async_ctrl_bench;

    localparam int AW  = 16;
    localparam int DW  = 16;
    localparam int LN  = DW / 8;
    localparam int RDC = 2;
    localparam int WRC = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req = 1'b0;
    logic          req_we = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic [LN-1:0] req_be = '0;
    logic          ready, rsp_valid;
    logic [DW-1:0] rsp_rdata;
    logic [AW-1:0] mem_addr;
    logic          mem_ce_n, mem_we_n, mem_oe_n;
    logic [LN-1:0] mem_bsel_n;
    logic [DW-1:0] mem_dq_o;
    logic          mem_dq_oe;
    logic [DW-1:0] mem_dq_i;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    logic [DW-1:0] model_mem [int];
    logic [DW-1:0] shadow [int];
    logic [DW-1:0] exp_q [$];
    string         tag_q [$];

    always #5 clk = ~clk;

    sram_async_ctrl #(
        .ADDR_W    (AW),
        .DATA_W    (DW),
        .RD_CYCLES (RDC),
        .WR_CYCLES (WRC)
    ) u_sram_async_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .req        (req),
        .req_we     (req_we),
        .req_addr   (req_addr),
        .req_wdata  (req_wdata),
        .req_be     (req_be),
        .ready      (ready),
        .rsp_valid  (rsp_valid),
        .rsp_rdata  (rsp_rdata),
        .mem_addr   (mem_addr),
        .mem_ce_n   (mem_ce_n),
        .mem_we_n   (mem_we_n),
        .mem_oe_n   (mem_oe_n),
        .mem_bsel_n (mem_bsel_n),
        .mem_dq_o   (mem_dq_o),
        .mem_dq_oe  (mem_dq_oe),
        .mem_dq_i   (mem_dq_i)
    );

    // Memory model: commits enabled lanes on the rising write strobe,
    // returns junk (8'hA5) on lanes that are not selected during a read.
    always @(posedge mem_we_n) begin
        if (mem_ce_n === 1'b0 && mem_dq_oe === 1'b1) begin
            logic [DW-1:0] w;
            w = model_mem.exists(int'(mem_addr)) ? model_mem[int'(mem_addr)] : '0;
            for (int l = 0; l < LN; l++)
                if (!mem_bsel_n[l]) w[l*8 +: 8] = mem_dq_o[l*8 +: 8];
            model_mem[int'(mem_addr)] = w;
        end
    end

    always @(mem_addr, mem_ce_n, mem_oe_n, mem_we_n, mem_bsel_n) begin
        logic [DW-1:0] w;
        w = model_mem.exists(int'(mem_addr)) ? model_mem[int'(mem_addr)] : '0;
        mem_dq_i = '0;
        if (mem_ce_n === 1'b0 && mem_oe_n === 1'b0 && mem_we_n === 1'b1)
            for (int l = 0; l < LN; l++)
                mem_dq_i[l*8 +: 8] = mem_bsel_n[l] ? 8'hA5 : w[l*8 +: 8];
    end

    task automatic chk(input bit ok, input string rq, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", rq, act, exp, $time);
        end
    endtask

    function automatic logic [DW-1:0] expect_read(input logic [AW-1:0] a,
                                                   input logic [LN-1:0] be);
        logic [DW-1:0] w;
        w = shadow.exists(int'(a)) ? shadow[int'(a)] : '0;
        for (int l = 0; l < LN; l++)
            if (!be[l]) w[l*8 +: 8] = 8'h00;
        return w;
    endfunction

    task automatic issue(input bit wr, input logic [AW-1:0] a,
                         input logic [DW-1:0] d, input logic [LN-1:0] be,
                         input string rq);
        @(negedge clk);
        while (!ready) @(negedge clk);
        if (wr) begin
            logic [DW-1:0] w;
            w = shadow.exists(int'(a)) ? shadow[int'(a)] : '0;
            for (int l = 0; l < LN; l++)
                if (be[l]) w[l*8 +: 8] = d[l*8 +: 8];
            shadow[int'(a)] = w;
        end else begin
            exp_q.push_back(expect_read(a, be));
            tag_q.push_back(rq);
        end
        req = 1'b1; req_we = wr; req_addr = a; req_wdata = d; req_be = be;
        @(negedge clk);
        req = 1'b0;
        chk(ready == 1'b0, "R9 busy after accept", 32'(ready), 32'd0);
    endtask

    // Monitor: scoreboard pop plus strobe timing checks
    logic prev_oe_n = 1'b1, prev_we_n = 1'b1, prev_dq_oe = 1'b0, prev_rvalid = 1'b0;
    int   oe_run = 0, we_run = 0;

    always @(negedge clk) begin
        if (rst_n && !finished) begin
            if (ready) chk(mem_ce_n == 1'b1, "R2 standby when ready", 32'(mem_ce_n), 32'd1);
            if (mem_dq_oe) chk(mem_oe_n == 1'b1, "R7 drive with oe off", 32'(mem_oe_n), 32'd1);
            if (prev_oe_n && !mem_oe_n) begin
                chk(prev_dq_oe == 1'b0, "R8 turnaround gap", 32'(prev_dq_oe), 32'd0);
                chk(mem_we_n == 1'b1, "R7 we high on read", 32'(mem_we_n), 32'd1);
            end
            if (!mem_oe_n) oe_run++;
            if (!prev_oe_n && mem_oe_n) begin
                chk(oe_run == RDC, "R3 read access length", 32'(oe_run), 32'(RDC));
                chk(rsp_valid == 1'b1, "R3 valid at oe release", 32'(rsp_valid), 32'd1);
                oe_run = 0;
            end
            if (!mem_we_n) we_run++;
            if (!prev_we_n && mem_we_n) begin
                chk(we_run == WRC, "R4 write pulse length", 32'(we_run), 32'(WRC));
                chk(mem_dq_oe && !mem_ce_n, "R4 hold after strobe rise",
                    {30'd0, mem_dq_oe, mem_ce_n}, 32'd2);
                we_run = 0;
            end
            if (rsp_valid) begin
                chk(!prev_rvalid, "R10 single-cycle valid", 32'(prev_rvalid), 32'd0);
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R10 valid without read", 32'd1, 32'd0);
                end else begin
                    logic [DW-1:0] e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    chk(rsp_rdata == e, t, 32'(rsp_rdata), 32'(e));
                end
            end
        end
        prev_oe_n   = mem_oe_n;
        prev_we_n   = mem_we_n;
        prev_dq_oe  = mem_dq_oe;
        prev_rvalid = rsp_valid;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state while reset is held
        chk({ready, rsp_valid, mem_dq_oe, mem_ce_n, mem_we_n, mem_oe_n, mem_bsel_n} == 8'b10011111,
            "R1 reset outputs",
            32'({ready, rsp_valid, mem_dq_oe, mem_ce_n, mem_we_n, mem_oe_n, mem_bsel_n}),
            32'b10011111);
        rst_n = 1'b1;
        @(negedge clk);
        chk({ready, mem_ce_n, mem_dq_oe} == 3'b110, "R1 idle after reset",
            32'({ready, mem_ce_n, mem_dq_oe}), 32'b110);

        // R3/R4: full words, address extremes
        issue(1'b1, 16'h0010, 16'h1234, 2'b11, "R4");
        issue(1'b0, 16'h0010, 16'h0000, 2'b11, "R3 full read");
        issue(1'b1, 16'hFFFF, 16'hABCD, 2'b11, "R4");
        issue(1'b1, 16'h0000, 16'h5A5A, 2'b11, "R4");
        issue(1'b0, 16'hFFFF, 16'h0000, 2'b11, "R3 top address");
        issue(1'b0, 16'h0000, 16'h0000, 2'b11, "R3 bottom address");

        // R5: lane writes
        issue(1'b1, 16'h0010, 16'h00FF, 2'b01, "R5");
        issue(1'b0, 16'h0010, 16'h0000, 2'b11, "R5 lower lane write");
        issue(1'b1, 16'h0010, 16'hEE00, 2'b10, "R5");
        issue(1'b0, 16'h0010, 16'h0000, 2'b11, "R5 upper lane write");

        // R6: masked read lanes and empty mask
        issue(1'b0, 16'h0010, 16'h0000, 2'b01, "R6 upper lane zero");
        issue(1'b0, 16'h0010, 16'h0000, 2'b10, "R6 lower lane zero");
        issue(1'b1, 16'h0010, 16'h0000, 2'b00, "R6");
        issue(1'b0, 16'h0010, 16'h0000, 2'b11, "R6 empty mask write");
        issue(1'b0, 16'hFFFF, 16'h0000, 2'b00, "R6 empty mask read");

        // R9: request while busy is ignored
        issue(1'b0, 16'h0000, 16'h0000, 2'b11, "R9 read before busy request");
        req = 1'b1; req_we = 1'b1; req_addr = 16'h0010; req_wdata = 16'h0BAD; req_be = 2'b11;
        @(negedge clk);
        req = 1'b0;
        issue(1'b0, 16'h0010, 16'h0000, 2'b11, "R9 busy request ignored");

        // R8: back-to-back write then read, walking addresses
        for (int i = 0; i < 8; i++) begin
            logic [AW-1:0] a;
            logic [DW-1:0] d;
            a = AW'(32'h1 << (2 * i));
            d = DW'((i * 32'h1111) ^ 32'h0F0F);
            issue(1'b1, a, d, 2'b11, "R8");
            issue(1'b0, a, 16'h0000, 2'b11, "R8 write then read");
        end

        repeat (12) @(negedge clk);
        chk(exp_q.size() == 0, "R10 one valid per read", 32'(exp_q.size()), 32'd0);
        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule